// File: doc/BRIEF.md
# Binary64 Multiply Special-Operand Front End

This block sits at the head of a binary64 multiplier. On a start pulse it classifies both operands and decides whether the product is settled without any mantissa arithmetic: a NaN operand, an infinity, an exact zero, or the invalid pairing of infinity with zero. A settled case produces the final 64-bit word and the invalid-flag update one cycle after start. A case that cannot be settled here is handed on to the multiply datapath, with both operands and the product sign. When the invalid trap is enabled, an invalid case raises a trap request and writes no result.

NaN handling follows a fixed precedence. The first operand's NaN is checked before the second's. A signaling NaN in the first operand therefore wins even when the second operand is also signaling. A returned signaling NaN is quieted by forcing the top fraction bit to the quiet polarity. The parameter `SNAN_VAL` sets which polarity marks a signaling NaN.

Top module: `fmul_special_front`

## Requirements
- R1: `done_o` is high exactly in the cycle after a cycle with `start_i` high. While `done_o` is high, exactly one of `result_vld_o`, `trap_invalid_o` and `need_dp_o` is high. While `done_o` is low, all three and `flag_invalid_o` are low.
- R2: Every infinity or zero result carries the XOR of bit 63 of the two operands as its sign.
- R3: If the first operand is a signaling NaN, the result is that operand quieted, and the invalid flag is raised. This holds whatever the second operand is, including a signaling NaN. A NaN has exponent bits 62:52 all ones and a nonzero fraction. By default it is signaling when bit 51 is 0 and quiet when bit 51 is 1. Quieting sets bit 51 to 1 and keeps every other bit.
- R4: If the first operand is a quiet NaN and the second is a signaling NaN, the result is the second operand quieted, and the invalid flag is raised. If the second operand is not a signaling NaN, the first operand is returned bit for bit, with no flag.
- R5: Infinity times an exact zero, in either order, produces the default quiet NaN 0x7FF8000000000000 and raises the invalid flag.
- R6: With `inv_trap_en_i` high, every case that would raise the invalid flag instead raises `trap_invalid_o`. In that case `result_vld_o` and `flag_invalid_o` stay low and `result_o` is zero.
- R7: Infinity times a non-NaN, nonzero operand, including another infinity, gives a signed infinity (exponent all ones, fraction zero) with no flag.
- R8: An exact zero (bits 62:0 all zero) times a finite operand gives a signed zero with no flag.
- R9: Two finite nonzero operands, subnormals included, give `need_dp_o`. In that case `dp_opa_o` and `dp_opb_o` equal the inputs, and `dp_sign_o` is their sign XOR.
- R10: If the first operand is not a NaN and the second is, the second operand is returned. It is quieted, with the invalid flag, when it is signaling; otherwise it is returned unchanged with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operands valid, begin classification |
| opa_i | input | 64 | First operand, binary64 |
| opb_i | input | 64 | Second operand, binary64 |
| inv_trap_en_i | input | 1 | Invalid-operation trap enable |
| done_o | output | 1 | Outcome valid, one cycle after start |
| result_vld_o | output | 1 | A final result is written on result_o |
| result_o | output | 64 | Final product word for settled cases |
| flag_invalid_o | output | 1 | Set the invalid flag |
| trap_invalid_o | output | 1 | Invalid trap request, no result written |
| need_dp_o | output | 1 | Normal multiplication required |
| dp_opa_o | output | 64 | First operand passed to the datapath |
| dp_opb_o | output | 64 | Second operand passed to the datapath |
| dp_sign_o | output | 1 | Product sign for the datapath |

## Verification
A wrong classification or a broken priority decode surfaces in the same `done_o` cycle that follows start. The most likely faults are a swapped NaN precedence, a missed signaling test, or a zero taken for a subnormal. At the ports they show up as the wrong NaN payload, a missing or spurious invalid flag, or a datapath hand-off where a settled result was due. The outcome registers are rewritten on every start, so a corrupted state cannot persist past the next operation.

// File: rtl/fmul_sp_pkg.sv
package fmul_sp_pkg;
  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_inf;
    logic is_zero;
  } opclass_t;

  typedef enum logic [1:0] {
    K_RES  = 2'd0,
    K_TRAP = 2'd1,
    K_DP   = 2'd2
  } kind_t;
endpackage

// File: rtl/fmul_sp_classify.sv
module fmul_sp_classify
  import fmul_sp_pkg::*;
#(
  parameter int   EXP_W    = 11,
  parameter int   FRAC_W   = 52,
  parameter logic SNAN_VAL = 1'b0,
  localparam int  W        = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output opclass_t     cls_o
);
  logic exp_max, frac_nz;

  always_comb begin
    exp_max       = &op_i[W-2:FRAC_W];
    frac_nz       = |op_i[FRAC_W-1:0];
    cls_o.is_nan  = exp_max & frac_nz;
    cls_o.is_snan = exp_max & frac_nz & (op_i[FRAC_W-1] == SNAN_VAL);
    cls_o.is_inf  = exp_max & ~frac_nz;
    cls_o.is_zero = ~|op_i[W-2:0];
  end
endmodule

// File: rtl/fmul_sp_resolve.sv
module fmul_sp_resolve
  import fmul_sp_pkg::*;
#(
  parameter int   EXP_W    = 11,
  parameter int   FRAC_W   = 52,
  parameter logic SNAN_VAL = 1'b0,
  localparam int  W        = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  opclass_t     cls_a_i,
  input  opclass_t     cls_b_i,
  input  logic         trap_en_i,
  output kind_t        kind_o,
  output logic [W-1:0] res_o,
  output logic         inv_o
);
  localparam logic QUIET = ~SNAN_VAL;
  localparam logic [W-1:0] DEF_NAN =
    {1'b0, {EXP_W{1'b1}}, QUIET, {(FRAC_W-1){~QUIET}}};

  function automatic logic [W-1:0] quieten(input logic [W-1:0] x);
    logic [W-1:0] y;
    y = x;
    y[FRAC_W-1] = QUIET;
    // quiet polarity 0 with empty payload would read as infinity
    if (!QUIET && y[FRAC_W-2:0] == '0) y[0] = 1'b1;
    return y;
  endfunction

  logic         sgn;
  logic [W-1:0] inf_w, zero_w, raw_res;
  logic         raw_inv, settled;

  always_comb begin
    sgn     = opa_i[W-1] ^ opb_i[W-1];
    inf_w   = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    zero_w  = {sgn, {(W-1){1'b0}}};
    raw_res = '0;
    raw_inv = 1'b0;
    settled = 1'b1;
    if (cls_a_i.is_nan) begin
      if (cls_a_i.is_snan) begin
        raw_res = quieten(opa_i); raw_inv = 1'b1;
      end else if (cls_b_i.is_snan) begin
        raw_res = quieten(opb_i); raw_inv = 1'b1;
      end else begin
        raw_res = opa_i;
      end
    end else if (cls_b_i.is_nan) begin
      raw_res = cls_b_i.is_snan ? quieten(opb_i) : opb_i;
      raw_inv = cls_b_i.is_snan;
    end else if (cls_a_i.is_inf || cls_b_i.is_inf) begin
      if (cls_a_i.is_zero || cls_b_i.is_zero) begin
        raw_res = DEF_NAN; raw_inv = 1'b1;
      end else begin
        raw_res = inf_w;
      end
    end else if (cls_a_i.is_zero || cls_b_i.is_zero) begin
      raw_res = zero_w;
    end else begin
      settled = 1'b0;
    end

    if (!settled) begin
      kind_o = K_DP;   res_o = '0;      inv_o = 1'b0;
    end else if (raw_inv && trap_en_i) begin
      kind_o = K_TRAP; res_o = '0;      inv_o = 1'b0;
    end else begin
      kind_o = K_RES;  res_o = raw_res; inv_o = raw_inv;
    end
  end
endmodule

// File: rtl/fmul_special_front.sv
module fmul_special_front
  import fmul_sp_pkg::*;
#(
  parameter int   EXP_W    = 11,
  parameter int   FRAC_W   = 52,
  parameter logic SNAN_VAL = 1'b0,
  localparam int  W        = 1 + EXP_W + FRAC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         inv_trap_en_i,
  output logic         done_o,
  output logic         result_vld_o,
  output logic [W-1:0] result_o,
  output logic         flag_invalid_o,
  output logic         trap_invalid_o,
  output logic         need_dp_o,
  output logic [W-1:0] dp_opa_o,
  output logic [W-1:0] dp_opb_o,
  output logic         dp_sign_o
);
  localparam logic QUIET = ~SNAN_VAL;

  opclass_t     cls_a, cls_b;
  kind_t        kind_d, kind_q;
  logic [W-1:0] res_d, res_q, opa_q, opb_q;
  logic         inv_d, inv_q, done_q;

  fmul_sp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SNAN_VAL(SNAN_VAL))
    u_cls_a (.op_i(opa_i), .cls_o(cls_a));
  fmul_sp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SNAN_VAL(SNAN_VAL))
    u_cls_b (.op_i(opb_i), .cls_o(cls_b));

  fmul_sp_resolve #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SNAN_VAL(SNAN_VAL))
    u_resolve (
      .opa_i(opa_i), .opb_i(opb_i), .cls_a_i(cls_a), .cls_b_i(cls_b),
      .trap_en_i(inv_trap_en_i), .kind_o(kind_d), .res_o(res_d), .inv_o(inv_d)
    );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      kind_q <= K_RES;
      res_q  <= '0;
      inv_q  <= 1'b0;
      opa_q  <= '0;
      opb_q  <= '0;
    end else begin
      done_q <= start_i;
      if (start_i) begin
        kind_q <= kind_d;
        res_q  <= res_d;
        inv_q  <= inv_d;
        opa_q  <= opa_i;
        opb_q  <= opb_i;
      end
    end
  end

  assign done_o         = done_q;
  assign result_vld_o   = done_q && (kind_q == K_RES);
  assign trap_invalid_o = done_q && (kind_q == K_TRAP);
  assign need_dp_o      = done_q && (kind_q == K_DP);
  assign result_o       = result_vld_o ? res_q : '0;
  assign flag_invalid_o = result_vld_o && inv_q;
  assign dp_opa_o       = opa_q;
  assign dp_opb_o       = opb_q;
  assign dp_sign_o      = opa_q[W-1] ^ opb_q[W-1];

  a_r1_done_follows_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  a_r1_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  a_r1_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({result_vld_o, trap_invalid_o, need_dp_o}) == 1);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(result_vld_o || trap_invalid_o || need_dp_o || flag_invalid_o));
  a_r6_trap_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_invalid_o |-> !flag_invalid_o && result_o == '0);
  a_r2_sign_xor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_o && !(&result_o[W-2:FRAC_W] && |result_o[FRAC_W-1:0]))
      |-> result_o[W-1] == (dp_opa_o[W-1] ^ dp_opb_o[W-1]));
  a_r3_nan_out_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_vld_o && &result_o[W-2:FRAC_W] && |result_o[FRAC_W-1:0])
      |-> result_o[FRAC_W-1] == QUIET);
  a_r9_dp_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    need_dp_o |-> !flag_invalid_o && result_o == '0);
endmodule

// File: tb/fmul_special_front_tb.sv
`timescale 1ns/1ps
module fmul_special_front_tb;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, trap_en = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        done, rvld, finv, tinv, ndp, dsgn;
  logic [63:0] res, dpa, dpb;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  fmul_special_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opa_i(opa), .opb_i(opb),
    .inv_trap_en_i(trap_en), .done_o(done), .result_vld_o(rvld), .result_o(res),
    .flag_invalid_o(finv), .trap_invalid_o(tinv), .need_dp_o(ndp),
    .dp_opa_o(dpa), .dp_opb_o(dpb), .dp_sign_o(dsgn)
  );

  localparam logic [63:0] QN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNA  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] SNAQ = 64'h7FF8_0000_0000_0001;
  localparam logic [63:0] SNB  = 64'hFFF4_0000_0000_0000;
  localparam logic [63:0] SNBQ = 64'hFFFC_0000_0000_0000;
  localparam logic [63:0] QNA  = 64'h7FF8_0000_0000_0123;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] NTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SUB  = 64'h0000_0000_0000_0001;

  localparam int N = 17;
  // kind: 0 result, 1 trap, 2 datapath
  localparam logic [63:0] VA [N] = '{SNA, QNA, QNA, PINF, NZ, PINF, SNA, PINF, NINF,
                                     NZ, NTWO, ONE, SUB, PINF, ONE, PZ, SNA};
  localparam logic [63:0] VB [N] = '{SNB, SNB, ONE, PZ, PINF, PZ, ONE, NTWO, NINF,
                                     ONE, PZ, NTWO, ONE, SNB, QNA, SNA, SNB};
  localparam logic        VT [N] = '{0, 0, 0, 0, 0, 1, 1, 0, 0,
                                     0, 0, 0, 0, 0, 0, 0, 1};
  localparam logic [1:0]  VK [N] = '{0, 0, 0, 0, 0, 1, 1, 0, 0,
                                     0, 0, 2, 2, 0, 0, 0, 1};
  localparam logic        VF [N] = '{1, 1, 0, 1, 1, 0, 0, 0, 0,
                                     0, 0, 0, 0, 1, 0, 1, 0};
  localparam logic [63:0] VR [N] = '{SNAQ, SNBQ, QNA, QN, QN, PZ, PZ, NINF, PINF,
                                     NZ, NZ, PZ, PZ, SNBQ, QNA, SNAQ, PZ};
  localparam string       VQ [N] = '{"R3", "R4", "R4", "R5", "R5", "R6", "R6", "R7", "R7",
                                     "R8", "R2", "R9", "R9", "R10", "R10", "R10", "R6"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic t);
    @(negedge clk);
    opa = a; opb = b; trap_en = t; start = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12; // reset state
    chk("R1 reset done", {63'd0, done}, 64'd0);
    chk("R1 reset outputs", {60'd0, rvld, finv, tinv, ndp}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 idle done", {63'd0, done}, 64'd0);

    for (int i = 0; i < N; i++) begin
      issue(VA[i], VB[i], VT[i]);
      chk({VQ[i], " done"}, {63'd0, done}, 64'd1);
      chk({VQ[i], " result_vld"}, {63'd0, rvld}, {63'd0, VK[i] == 2'd0});
      chk({VQ[i], " trap"}, {63'd0, tinv}, {63'd0, VK[i] == 2'd1});
      chk({VQ[i], " need_dp"}, {63'd0, ndp}, {63'd0, VK[i] == 2'd2});
      chk({VQ[i], " flag"}, {63'd0, finv}, {63'd0, VF[i]});
      chk({VQ[i], " result"}, res, VR[i]);
      if (VK[i] == 2'd2) begin
        chk("R9 dp_opa", dpa, VA[i]);
        chk("R9 dp_opb", dpb, VB[i]);
        chk("R9 dp_sign", {63'd0, dsgn}, {63'd0, VA[i][63] ^ VB[i][63]});
      end
    end

    // R1: start dropped, done must fall next cycle
    @(negedge clk); start = 1'b0;
    @(posedge clk); #1;
    chk("R1 done drops", {63'd0, done}, 64'd0);
    chk("R1 outputs idle", {60'd0, rvld, finv, tinv, ndp}, 64'd0);

    // R2: negative zero times negative finite gives positive zero
    issue(NZ, NTWO, 1'b0);
    chk("R2 pos zero", res, PZ);
    // R7 with trap enabled: no invalid, so a result is still written
    issue(NINF, ONE, 1'b1);
    chk("R7 inf trap_en result", res, NINF);
    chk("R7 inf trap_en no trap", {63'd0, tinv}, 64'd0);
    // R8: zero times subnormal is settled, not sent to datapath
    issue(PZ, SUB, 1'b0);
    chk("R8 zero x sub", {62'd0, rvld, ndp}, 64'd2);
    chk("R8 zero x sub value", res, PZ);

    @(negedge clk); start = 1'b0;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule